// File: doc/BRIEF.md
# Scratch RAM, Parallel Port and Interval Timer Peripheral

This block is a small bus-attached peripheral for a byte-wide microcontroller bus. It holds a 256-byte scratch RAM, three parallel ports (two of 8 lines and one of 6 lines, 22 lines in all) and a 14-bit down-counting interval timer. A single space-select input picks the target. When it is low, the 8-bit address reaches the RAM. When it is high, the low address values reach six peripheral registers.

A control register sets the direction of each port. The top two bits of each write to that register also issue a timer command. The timer counts edges of a slow external timer clock, which is sampled in the bus clock domain. At the end of each period it raises a one-cycle terminal-count pulse. In continuous mode it then restarts from the programmed value; in single mode it stops. Bus writes are synchronous to `clk`. Read data is combinational and is driven only while the block is selected and read.

Top module: `ram_io_timer`

## Requirements
- R1: With `io_sel` low, a selected write stores `wdata` at RAM location `addr` (0x00 to 0xFF). A selected read returns the stored byte.
- R2: With `io_sel` high, `addr` 0 is the control register, 1 is port A, 2 is port B, 3 is port C (bits 5:0), 4 is the timer count low byte, and 5 is the high register. Any other address reads 0x00, and writes to it change no register.
- R3: After reset, `pa_oe`, `pb_oe`, `pc_oe` and `tmr_tc` are 0, the control register reads 0x00, and a port read returns the pin values.
- R4: A control write sets `pa_oe` from bit 0 and `pb_oe` from bit 1. It sets `pc_oe` only when bits 3 and 2 are both 1. Reading the control register returns bits 3:0 with bits 7:4 as zero.
- R5: Reading a port set as output returns its output latch. Reading a port set as input returns its input pins. The `*_out` pins always show the latch.
- R6: The high register holds count bits 13:8 in bits 5:0 and the mode in bits 7:6; bit 6 set means continuous mode. Registers 4 and 5 read back as written.
- R7: Control bits 7:6 are a timer command. 11 loads the 14-bit count and starts the timer. 01 stops it at once. 10 makes a running timer stop at its next terminal count. 00 has no effect.
- R8: While running, each rising edge of `tmr_clk` lowers the count by one. The edge that finds a count of 1 or 0 ends the period and raises `tmr_tc` for exactly one `clk` cycle. A loaded count of 0 ends at the first edge.
- R9: At the end of a period, continuous mode reloads the programmed count and keeps running. Single mode stops.
- R10: `rdata_oe` is high only while `sel` and `rd` are both high, and `rdata` is 0x00 whenever `rdata_oe` is low.
- R11: A write strobe while `sel` is low changes neither RAM nor registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| io_sel | input | 1 | 0 selects the RAM, 1 selects the registers |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 8 | Latched address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data bus enable |
| pa_in | input | 8 | Port A pins |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A drives its pins |
| pb_in | input | 8 | Port B pins |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B drives its pins |
| pc_in | input | 6 | Port C pins |
| pc_out | output | 6 | Port C output latch |
| pc_oe | output | 1 | Port C drives its pins |
| tmr_clk | input | 1 | Timer count clock, slower than half of `clk` |
| tmr_tc | output | 1 | Terminal-count pulse |

## Verification
Some properties are checked on every cycle. The terminal-count pulse never lasts two cycles. The port enables follow the last control write. A stop command leaves the next cycle free of pulses. The data bus reads zero whenever it is not enabled. Only the bench scenarios can show which timer edge ends a period: single versus continuous periods, a loaded zero, a deferred stop, and a command of 00 that changes nothing. The same holds for the port read-back choice between latch and pins, RAM contents at both ends of the range, and writes that must be ignored.

// File: rtl/ram_io_timer.sv
module ram_io_timer #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       io_sel,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rdata_oe,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic       pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic       pb_oe,
  input  logic [5:0] pc_in,
  output logic [5:0] pc_out,
  output logic       pc_oe,
  input  logic       tmr_clk,
  output logic       tmr_tc
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = CNT_W - 8;

  logic [7:0]       mem [DEPTH];
  logic [3:0]       dir;
  logic [7:0]       pa_q, pb_q;
  logic [5:0]       pc_q;
  logic [7:0]       cnt_lo, cnt_hi;
  logic [CNT_W-1:0] cnt;
  logic             running, stop_at_tc, tclk_q, tc_q;

  wire bus_wr  = sel & wr;
  wire io_wr   = bus_wr & io_sel;
  wire cmd_wr  = io_wr && addr == 8'd0;
  wire tedge   = tmr_clk & ~tclk_q;
  wire [CNT_W-1:0] reload = {cnt_hi[HI_W-1:0], cnt_lo};

  assign pa_oe    = dir[0];
  assign pb_oe    = dir[1];
  assign pc_oe    = &dir[3:2];
  assign pa_out   = pa_q;
  assign pb_out   = pb_q;
  assign pc_out   = pc_q;
  assign tmr_tc   = tc_q;
  assign rdata_oe = sel & rd;

  always_ff @(posedge clk)
    if (bus_wr && !io_sel) mem[addr] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= '0; pa_q <= '0; pb_q <= '0; pc_q <= '0;
      cnt_lo <= '0; cnt_hi <= '0; cnt <= '0;
      running <= 1'b0; stop_at_tc <= 1'b0; tclk_q <= 1'b0; tc_q <= 1'b0;
    end else begin
      tclk_q <= tmr_clk;
      tc_q   <= 1'b0;
      if (io_wr) begin
        case (addr)
          8'd1: pa_q <= wdata;
          8'd2: pb_q <= wdata;
          8'd3: pc_q <= wdata[5:0];
          8'd4: cnt_lo <= wdata;
          8'd5: cnt_hi <= wdata;
          default: ;
        endcase
      end
      if (cmd_wr) begin
        dir <= wdata[3:0];
        case (wdata[7:6])
          2'b01: begin running <= 1'b0; stop_at_tc <= 1'b0; end
          2'b10: stop_at_tc <= running;
          2'b11: begin cnt <= reload; running <= 1'b1; stop_at_tc <= 1'b0; end
          default: ;
        endcase
      end else if (running && tedge) begin
        if (cnt <= CNT_W'(1)) begin
          tc_q <= 1'b1;
          if (cnt_hi[6] && !stop_at_tc) cnt <= reload;
          else begin
            running <= 1'b0; stop_at_tc <= 1'b0; cnt <= '0;
          end
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rdata_oe) begin
      if (!io_sel) rdata = mem[addr];
      else begin
        case (addr)
          8'd0: rdata = {4'b0, dir};
          8'd1: rdata = dir[0] ? pa_q : pa_in;
          8'd2: rdata = dir[1] ? pb_q : pb_in;
          8'd3: rdata = {2'b0, pc_oe ? pc_q : pc_in};
          8'd4: rdata = cnt_lo;
          8'd5: rdata = cnt_hi;
          default: rdata = '0;
        endcase
      end
    end
  end

  assert_tc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tc |=> !tmr_tc);

  assert_dir_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (pa_oe == $past(wdata[0]) && pb_oe == $past(wdata[1])
                && pc_oe == $past(wdata[3] & wdata[2])));

  assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[7:6] == 2'b01) |=> (!tmr_tc && !running) ##1 !tmr_tc);

  assert_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == 8'h00);

  assert_tc_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tc |-> $past(running));
endmodule

// File: tb/ram_io_timer_tb.sv
`timescale 1ns/1ps
module ram_io_timer_tb;
  logic clk = 0, rst_n = 0;
  logic sel = 0, io_sel = 0, rd = 0, wr = 0, tmr_clk = 0;
  logic [7:0] addr = 0, wdata = 0, pa_in = 8'h3C, pb_in = 8'hC3;
  logic [5:0] pc_in = 6'h15;
  logic [7:0] rdata, pa_out, pb_out;
  logic [5:0] pc_out;
  logic rdata_oe, pa_oe, pb_oe, pc_oe, tmr_tc;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  ram_io_timer u_dut (.clk, .rst_n, .sel, .io_sel, .rd, .wr, .addr, .wdata,
    .rdata, .rdata_oe, .pa_in, .pa_out, .pa_oe, .pb_in, .pb_out, .pb_oe,
    .pc_in, .pc_out, .pc_oe, .tmr_clk, .tmr_tc);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input bit io, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; io_sel = io; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input bit io, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; io_sel = io; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic tick(output logic tc);
    @(negedge clk); tmr_clk = 1;
    @(negedge clk); tc = tmr_tc; tmr_clk = 0;
    @(negedge clk);
  endtask

  task automatic expect_rd(input bit io, input logic [7:0] a, input logic [7:0] e, input string req);
    logic [7:0] d;
    bus_rd(io, a, d);
    chk(d == e, req, d, e);
  endtask

  task automatic run_ticks(input int n, input int period, input int stop_after, input string req);
    logic tc;
    for (int i = 1; i <= n; i++) begin
      tick(tc);
      chk(tc == ((i % period == 0) && i <= stop_after), req, tc, i);
    end
  endtask

  task automatic t_reset;
    chk(!pa_oe && !pb_oe && !pc_oe, "R3 oe", {pa_oe, pb_oe, pc_oe}, 0);
    chk(!tmr_tc, "R3 tc", tmr_tc, 0);
    chk(!rdata_oe && rdata == 0, "R10 idle", rdata, 0);
    expect_rd(1, 0, 8'h00, "R3 cmd");
    expect_rd(1, 1, 8'h3C, "R3 pa pins");
    expect_rd(1, 3, 8'h15, "R3 pc pins");
  endtask

  task automatic t_ram;
    bus_wr(0, 8'h00, 8'h5A);
    bus_wr(0, 8'hFF, 8'hA7);
    bus_wr(0, 8'h42, 8'h19);
    expect_rd(0, 8'h00, 8'h5A, "R1 low");
    expect_rd(0, 8'hFF, 8'hA7, "R1 high");
    expect_rd(0, 8'h42, 8'h19, "R1 mid");
    @(negedge clk); sel = 0; io_sel = 0; wr = 1; addr = 8'h42; wdata = 8'hEE;
    @(negedge clk); wr = 0;
    expect_rd(0, 8'h42, 8'h19, "R11 ram");
  endtask

  task automatic t_bus;
    @(negedge clk); sel = 1; rd = 0; io_sel = 0; addr = 0;
    #1 chk(!rdata_oe && rdata == 0, "R10 no rd", rdata_oe, 0);
    @(negedge clk); sel = 0; rd = 1;
    #1 chk(!rdata_oe && rdata == 0, "R10 no sel", rdata_oe, 0);
    @(negedge clk); rd = 0;
  endtask

  task automatic t_ports;
    bus_wr(1, 1, 8'hA5);
    chk(pa_out == 8'hA5 && !pa_oe, "R5 latch pin", pa_out, 8'hA5);
    expect_rd(1, 1, 8'h3C, "R5 input reads pins");
    bus_wr(1, 0, 8'h01);
    chk(pa_oe && !pb_oe && !pc_oe, "R4 pa only", {pa_oe, pb_oe, pc_oe}, 3'b100);
    expect_rd(1, 1, 8'hA5, "R5 output reads latch");
    bus_wr(1, 3, 8'h2A);
    bus_wr(1, 0, 8'h06);
    chk(!pa_oe && pb_oe && !pc_oe, "R4 pc needs both", {pa_oe, pb_oe, pc_oe}, 3'b010);
    expect_rd(1, 3, 8'h15, "R5 pc input");
    bus_wr(1, 0, 8'h0F);
    chk(pa_oe && pb_oe && pc_oe, "R4 all out", {pa_oe, pb_oe, pc_oe}, 3'b111);
    expect_rd(1, 3, 8'h2A, "R5 pc latch");
    expect_rd(1, 0, 8'h0F, "R4 cmd readback");
    @(negedge clk); sel = 0; io_sel = 1; wr = 1; addr = 1; wdata = 8'h00;
    @(negedge clk); wr = 0;
    expect_rd(1, 1, 8'hA5, "R11 reg");
    bus_wr(1, 6, 8'hFF);
    expect_rd(1, 6, 8'h00, "R2 off6");
    expect_rd(1, 0, 8'h0F, "R2 cmd kept");
    expect_rd(1, 2, 8'h00, "R2 pb kept");
    bus_wr(1, 0, 8'h00);
  endtask

  task automatic t_tregs;
    bus_wr(1, 4, 8'h12);
    bus_wr(1, 5, 8'hC7);
    expect_rd(1, 4, 8'h12, "R6 low");
    expect_rd(1, 5, 8'hC7, "R6 high");
  endtask

  task automatic t_single;
    bus_wr(1, 4, 8'd3); bus_wr(1, 5, 8'h00); bus_wr(1, 0, 8'hC0);
    run_ticks(6, 3, 3, "R9 single R8");
  endtask

  task automatic t_cont;
    bus_wr(1, 4, 8'd2); bus_wr(1, 5, 8'h40); bus_wr(1, 0, 8'hC0);
    run_ticks(6, 2, 99, "R9 continuous");
    bus_wr(1, 0, 8'h00);
    run_ticks(2, 2, 99, "R7 nop");
    bus_wr(1, 0, 8'h40);
  endtask

  task automatic t_stop;
    logic tc;
    bus_wr(1, 4, 8'd5); bus_wr(1, 5, 8'h40); bus_wr(1, 0, 8'hC0);
    tick(tc); tick(tc);
    bus_wr(1, 0, 8'h40);
    run_ticks(6, 1, 0, "R7 stop");
    bus_wr(1, 4, 8'd2); bus_wr(1, 0, 8'hC0); bus_wr(1, 0, 8'h80);
    run_ticks(6, 2, 2, "R7 stop at tc");
  endtask

  task automatic t_zero;
    logic tc;
    bus_wr(1, 4, 8'd0); bus_wr(1, 5, 8'h00); bus_wr(1, 0, 8'hC0);
    tick(tc);
    chk(tc, "R8 zero count", tc, 1);
    tick(tc);
    chk(!tc, "R8 zero stops", tc, 0);
    bus_wr(1, 4, 8'h00); bus_wr(1, 5, 8'h01); bus_wr(1, 0, 8'hC0);
    run_ticks(256, 256, 256, "R8 high bits");
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_ram; t_bus; t_ports; t_tregs;
    t_single; t_cont; t_stop; t_zero;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule